// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external SPI master read and write a 32-entry byte register space that sits on a simple local register bus. Every transaction is 16 serial bits long. The first byte is a command and the second byte is data. The command byte holds a direction bit, two reserved bits and a register address. The data byte is captured from SDI on a write. On a read, the data byte is driven onto SDO from the addressed register.

The serial pins are brought into the system clock domain through two-flop synchronisers, and SCK edges are detected there. The system clock must run at least four times faster than SCK. Configuration inputs control four things: the idle level of SCK, which SCK edge samples data, whether bits travel MSB or LSB first, and whether the select pin is honoured. Local logic can preload a byte that is sent out during the command byte.

Two sticky flags record two kinds of misuse:
- a frame that was cut short by deselection;
- a preload attempted while a frame was in flight.

Each flag is cleared only by its own clear strobe.

Top module: `spi_regport`

## Requirements
- R1: A command byte holds the direction in bit 7 (1 = read, 0 = write), reserved bits in 6..5 and the register address in bits 4..0. A frame is 16 captured bits: the command byte followed by the data byte.
- R2: On a write command, a single-cycle `reg_wr` pulse carries the address and the second byte on `reg_addr`/`reg_wdata`. The pulse follows the 16th capture edge.
- R3: On a read command, a single-cycle `reg_rd` pulse follows the 8th capture edge. `reg_rdata` is latched in that cycle and shifted out on SDO during the second byte.
- R4: A command with either reserved bit set produces neither `reg_wr` nor `reg_rd`, and its second byte on SDO is all zeros.
- R5: `cfg_cpol` = 0 means SCK idles high and 1 means it idles low. Data is captured on the rising SCK edge when `cfg_cpol` equals `cfg_cedge`, and on the falling edge otherwise.
- R6: `cfg_msb_first` = 1 sends and receives each byte MSB first; 0 sends and receives LSB first. This applies to both bytes in both directions.
- R7: With `cfg_cs_en` = 1, a high `spi_scs_n` deselects the port, so SCK edges are ignored and the bit count is held at zero. With `cfg_cs_en` = 0, `spi_scs_n` is ignored and the port is always selected.
- R8: `flag_incomplete` sets when the port is deselected with 1 to 15 bits of a frame captured. It stays set until `clr_incomplete` is pulsed. Deselection with no bits captured leaves it clear.
- R9: A `loc_load` pulse while no frame is in progress stores `loc_data`. The stored byte is sent on SDO during the command byte of every following frame.
- R10: A `loc_load` pulse while a frame is in progress is discarded and sets `flag_collide`. The flag stays set until `clr_collide` is pulsed.
- R11: `spi_sdo_oe` is low whenever `cfg_cs_en` = 1 and `spi_scs_n` is high, and high otherwise.
- R12: After reset, both flags and both strobes are low and the stored preload byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCK idle level select (0 idle high, 1 idle low) |
| cfg_cedge | input | 1 | Capture edge select, decoded together with cfg_cpol |
| cfg_msb_first | input | 1 | Bit order (1 MSB first, 0 LSB first) |
| cfg_cs_en | input | 1 | Honour the select pin when 1 |
| spi_sck | input | 1 | Serial clock from the master |
| spi_sdi | input | 1 | Serial data from the master |
| spi_scs_n | input | 1 | Active-low slave select |
| spi_sdo | output | 1 | Serial data to the master |
| spi_sdo_oe | output | 1 | SDO pad drive enable (low = tri-state) |
| reg_addr | output | 5 | Register bus address |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rd | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, valid in the cycle of reg_rd |
| loc_load | input | 1 | Local preload strobe |
| loc_data | input | 8 | Local preload byte |
| clr_incomplete | input | 1 | Clears flag_incomplete |
| clr_collide | input | 1 | Clears flag_collide |
| flag_incomplete | output | 1 | Sticky cut-short-frame flag |
| flag_collide | output | 1 | Sticky preload-collision flag |

## Verification
The hardest state to reach from the ports is a preload colliding with a frame that is part way through. It needs a master that stops in the middle of a byte, which a normal transaction never does. The bench shifts exactly three bits and parks SCK at idle. It pulses the preload, then raises the select to abandon the frame. This one stimulus sets both sticky flags. A full read that follows shows that the earlier preload byte survived.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int unsigned SPR_BYTE_W = 8;
  localparam int unsigned SPR_ADDR_W = 5;
  localparam int unsigned SPR_IDX_W  = $clog2(SPR_BYTE_W);
  localparam int unsigned SPR_CNT_W  = $clog2(2 * SPR_BYTE_W);

  // Capture on the rising edge when polarity and edge bits agree.
  function automatic logic capture_on_rise(input logic cpol, input logic cedge);
    return cpol == cedge;
  endfunction

  function automatic logic [SPR_BYTE_W-1:0] shift_in(input logic [SPR_BYTE_W-1:0] cur,
                                                     input logic b, input logic msb_first);
    return msb_first ? {cur[SPR_BYTE_W-2:0], b} : {b, cur[SPR_BYTE_W-1:1]};
  endfunction

  // Byte bit index transmitted in a given slot of the byte.
  function automatic logic [SPR_IDX_W-1:0] bit_pos(input logic [SPR_IDX_W-1:0] slot,
                                                   input logic msb_first);
    return msb_first ? (SPR_IDX_W'(SPR_BYTE_W - 1) - slot) : slot;
  endfunction

  function automatic logic cmd_is_read(input logic [SPR_BYTE_W-1:0] c);
    return c[SPR_BYTE_W-1];
  endfunction

  // True when every bit between the address field and the direction bit is zero.
  function automatic logic cmd_rsv_clear(input logic [SPR_BYTE_W-1:0] c, input int unsigned aw);
    logic [SPR_BYTE_W-2:0] low;
    low = c[SPR_BYTE_W-2:0];
    return (low >> aw) == '0;
  endfunction
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/spi_regport_engine.sv
module spi_regport_engine
  import spi_regport_pkg::*;
#(
  parameter int unsigned ADDR_W = SPR_ADDR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck_pin,
  input  logic                  sdi_pin,
  input  logic                  scs_n_pin,
  input  logic                  cfg_cpol,
  input  logic                  cfg_cedge,
  input  logic                  cfg_msb_first,
  input  logic                  cfg_cs_en,
  output logic [SPR_CNT_W-1:0]  bit_cnt,
  output logic                  busy,
  output logic                  frame_abort,
  output logic                  cmd_done,
  output logic                  rd_go,
  output logic                  wr_go,
  output logic [ADDR_W-1:0]     cmd_addr,
  output logic [SPR_BYTE_W-1:0] wdata
);
  localparam logic [SPR_CNT_W-1:0] CMD_LAST = SPR_CNT_W'(SPR_BYTE_W - 1);

  logic [2:0] pins_s;
  logic       sck_s, sdi_s, scs_n_s, sck_p, sel, sel_p, primed, cap_evt, sck_rise, sck_fall;
  logic [1:0] prime_cnt;
  logic [SPR_BYTE_W-1:0] rx, rx_next, cmd_q;

  spi_regport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scs_n_pin, sdi_pin, sck_pin}), .q(pins_s)
  );
  assign {scs_n_s, sdi_s, sck_s} = pins_s;

  assign sel         = !cfg_cs_en || !scs_n_s;
  assign primed      = prime_cnt == 2'd3;
  assign sck_rise    = sck_s && !sck_p;
  assign sck_fall    = !sck_s && sck_p;
  assign cap_evt     = sel && primed && (capture_on_rise(cfg_cpol, cfg_cedge) ? sck_rise : sck_fall);
  assign rx_next     = shift_in(rx, sdi_s, cfg_msb_first);
  assign busy        = bit_cnt != '0;
  assign frame_abort = sel_p && !sel && busy;
  assign cmd_addr    = cmd_q[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p     <= 1'b0;
      prime_cnt <= '0;
      sel_p     <= 1'b0;
      bit_cnt   <= '0;
      rx        <= '0;
      cmd_q     <= '0;
      wdata     <= '0;
      cmd_done  <= 1'b0;
      rd_go     <= 1'b0;
      wr_go     <= 1'b0;
    end else begin
      sck_p    <= sck_s;
      sel_p    <= sel;
      cmd_done <= 1'b0;
      rd_go    <= 1'b0;
      wr_go    <= 1'b0;
      if (!primed) prime_cnt <= prime_cnt + 2'd1;
      if (!sel) begin
        bit_cnt <= '0;
      end else if (cap_evt) begin
        rx      <= rx_next;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CMD_LAST) begin
          cmd_q    <= rx_next;
          cmd_done <= 1'b1;
          rd_go    <= cmd_is_read(rx_next) && cmd_rsv_clear(rx_next, ADDR_W);
        end
        if (bit_cnt == '1) begin
          wdata <= rx_next;
          wr_go <= !cmd_is_read(cmd_q) && cmd_rsv_clear(cmd_q, ADDR_W);
        end
      end
    end
  end

  AST_DESEL_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> bit_cnt == '0); // R7
  AST_WRITE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> $past(cap_evt)); // R2
  AST_RESERVED_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go || wr_go) |-> cmd_rsv_clear(cmd_q, ADDR_W)); // R4
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int unsigned ADDR_W = SPR_ADDR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_cpol,
  input  logic                  cfg_cedge,
  input  logic                  cfg_msb_first,
  input  logic                  cfg_cs_en,
  input  logic                  spi_sck,
  input  logic                  spi_sdi,
  input  logic                  spi_scs_n,
  output logic                  spi_sdo,
  output logic                  spi_sdo_oe,
  output logic [ADDR_W-1:0]     reg_addr,
  output logic                  reg_wr,
  output logic [SPR_BYTE_W-1:0] reg_wdata,
  output logic                  reg_rd,
  input  logic [SPR_BYTE_W-1:0] reg_rdata,
  input  logic                  loc_load,
  input  logic [SPR_BYTE_W-1:0] loc_data,
  input  logic                  clr_incomplete,
  input  logic                  clr_collide,
  output logic                  flag_incomplete,
  output logic                  flag_collide
);
  logic [SPR_CNT_W-1:0]  bit_cnt;
  logic                  busy, frame_abort, cmd_done, rd_go, wr_go, load_clash;
  logic [SPR_BYTE_W-1:0] tx_hold, rd_byte;
  logic [SPR_IDX_W-1:0]  out_pos;

  spi_regport_engine #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .sck_pin(spi_sck), .sdi_pin(spi_sdi), .scs_n_pin(spi_scs_n),
    .cfg_cpol(cfg_cpol), .cfg_cedge(cfg_cedge),
    .cfg_msb_first(cfg_msb_first), .cfg_cs_en(cfg_cs_en),
    .bit_cnt(bit_cnt), .busy(busy), .frame_abort(frame_abort),
    .cmd_done(cmd_done), .rd_go(rd_go), .wr_go(wr_go),
    .cmd_addr(reg_addr), .wdata(reg_wdata)
  );

  assign load_clash = loc_load && busy;
  assign reg_wr     = wr_go;
  assign reg_rd     = rd_go;
  assign out_pos    = bit_pos(bit_cnt[SPR_IDX_W-1:0], cfg_msb_first);
  assign spi_sdo    = bit_cnt[SPR_CNT_W-1] ? rd_byte[out_pos] : tx_hold[out_pos];
  assign spi_sdo_oe = !cfg_cs_en || !spi_scs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold         <= '0;
      rd_byte         <= '0;
      flag_incomplete <= 1'b0;
      flag_collide    <= 1'b0;
    end else begin
      if (loc_load && !busy) tx_hold <= loc_data;
      if (cmd_done) rd_byte <= rd_go ? reg_rdata : '0;
      if (frame_abort)         flag_incomplete <= 1'b1;
      else if (clr_incomplete) flag_incomplete <= 1'b0;
      if (load_clash)          flag_collide <= 1'b1;
      else if (clr_collide)    flag_collide <= 1'b0;
    end
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd)); // R3
  AST_ABORT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> flag_incomplete); // R8
  AST_CLASH_DISCARDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_clash |=> (flag_collide && $stable(tx_hold))); // R10
  AST_COLLIDE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_collide && !clr_collide) |=> flag_collide); // R10
  AST_SDO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cs_en && spi_scs_n) |-> !spi_sdo_oe); // R11
endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cedge = 1'b0, cfg_msb_first = 1'b1, cfg_cs_en = 1'b1;
  logic sck = 1'b1, sdi = 1'b0, scs_n = 1'b1;
  logic sdo, sdo_oe, reg_wr, reg_rd, loc_load = 1'b0;
  logic clr_inc = 1'b0, clr_col = 1'b0, f_inc, f_col;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, loc_data = 8'h00;
  logic [7:0] mem [32];
  int total = 0, bad = 0, wr_cnt = 0, rd_cnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_regport uut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cedge(cfg_cedge),
    .cfg_msb_first(cfg_msb_first), .cfg_cs_en(cfg_cs_en),
    .spi_sck(sck), .spi_sdi(sdi), .spi_scs_n(scs_n), .spi_sdo(sdo), .spi_sdo_oe(sdo_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .loc_load(loc_load), .loc_data(loc_data),
    .clr_incomplete(clr_inc), .clr_collide(clr_col),
    .flag_incomplete(f_inc), .flag_collide(f_col)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] <= 8'h00;
    end else begin
      if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
      if (reg_rd) rd_cnt <= rd_cnt + 1;
    end
  end

  // {cpol, cedge, msb_first, cs_en, address, data}
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 8'h5A},
    {1'b0, 1'b1, 1'b1, 1'b1, 8'h02, 8'hC3},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'h03, 8'h81},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h04, 8'h7E},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h1F, 8'h96},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h10, 8'h3C},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h05, 8'hE1},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h06, 8'h18}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift nbits of a two-byte word; the master samples SDO just before each capture edge.
  task automatic xfer(input logic [15:0] word, input int nbits, output logic [15:0] got);
    logic pre_lvl, idle_lvl;
    pre_lvl  = (cfg_cpol == cfg_cedge) ? 1'b0 : 1'b1;
    idle_lvl = cfg_cpol ? 1'b0 : 1'b1;
    got = 16'h0000;
    for (int k = 0; k < nbits; k++) begin
      int j, pos, base;
      logic [7:0] byt;
      j    = k % 8;
      base = (k < 8) ? 8 : 0;
      byt  = (k < 8) ? word[15:8] : word[7:0];
      pos  = cfg_msb_first ? 7 - j : j;
      if (sck != pre_lvl) begin sck = pre_lvl; wait_clk(HALF); end
      sdi = byt[pos];
      wait_clk(HALF);
      got[base + pos] = sdo;
      sck = ~sck;
      wait_clk(HALF);
    end
    if (sck != idle_lvl) begin sck = idle_lvl; wait_clk(HALF); end
  endtask

  task automatic txn(input logic [7:0] cmd, input logic [7:0] data, output logic [15:0] got);
    if (cfg_cs_en) begin scs_n = 1'b0; wait_clk(4); end
    xfer({cmd, data}, 16, got);
    if (cfg_cs_en) scs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic set_cfg(input logic cpol, input logic cedge, input logic msb, input logic csen);
    cfg_cs_en = 1'b1;
    scs_n = 1'b1;
    wait_clk(4);
    cfg_cpol = cpol;
    cfg_cedge = cedge;
    cfg_msb_first = msb;
    sck = cpol ? 1'b0 : 1'b1;
    wait_clk(6);
    cfg_cs_en = csen;
    wait_clk(4);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    wait_clk(1);
    s = 1'b0;
  endtask

  initial begin
    logic [15:0] got;
    int w0, r0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // Reset state
    chk("R12 flags", {f_inc, f_col}, 16'h0);
    chk("R12 strobes", {reg_wr, reg_rd}, 16'h0);
    chk("R11 deselected oe", sdo_oe, 1'b0);
    txn(8'h80, 8'h00, got);
    chk("R12 preload zero", got[15:8], 8'h00);
    chk("R3 read after reset", got[7:0], 8'h00);

    // Table: write then read back under each configuration
    foreach (VEC[i]) begin
      logic [7:0] a, d;
      a = VEC[i][15:8];
      d = VEC[i][7:0];
      set_cfg(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16]);
      w0 = wr_cnt;
      txn({3'b000, a[4:0]}, d, got);
      chk("R2 write strobe count", 16'(wr_cnt - w0), 16'd1);
      chk("R1 R5 R6 register written", mem[a[4:0]], d);
      txn({3'b100, a[4:0]}, 8'h00, got);
      chk("R3 R5 R6 read data on SDO", got[7:0], d);
    end

    set_cfg(1'b0, 1'b0, 1'b1, 1'b1);

    // R9 preload while idle
    loc_data = 8'hA5;
    pulse(loc_load);
    wait_clk(2);
    txn(8'h09, 8'h11, got);
    chk("R9 preload on command byte", got[15:8], 8'hA5);

    // R11 pad enable
    scs_n = 1'b0;
    wait_clk(1);
    chk("R11 selected oe", sdo_oe, 1'b1);
    scs_n = 1'b1;
    cfg_cs_en = 1'b0;
    wait_clk(1);
    chk("R11 select ignored oe", sdo_oe, 1'b1);
    cfg_cs_en = 1'b1;
    wait_clk(4);

    // R10 and R8: stop three bits into a frame, preload, then abandon it
    w0 = wr_cnt;
    scs_n = 1'b0;
    wait_clk(4);
    xfer(16'h0977, 3, got);
    loc_data = 8'h3C;
    pulse(loc_load);
    wait_clk(2);
    chk("R10 collision flag set", f_col, 1'b1);
    scs_n = 1'b1;
    wait_clk(6);
    chk("R8 incomplete flag set", f_inc, 1'b1);
    chk("R8 abandoned frame no write", 16'(wr_cnt - w0), 16'd0);
    txn(8'h89, 8'h00, got);
    chk("R10 preload discarded", got[15:8], 8'hA5);
    chk("R3 read register 9", got[7:0], 8'h11);
    chk("R10 collision sticky", f_col, 1'b1);
    chk("R8 incomplete sticky", f_inc, 1'b1);
    pulse(clr_inc);
    pulse(clr_col);
    wait_clk(2);
    chk("R8 R10 flags cleared", {f_inc, f_col}, 16'h0);
    txn(8'h0A, 8'h22, got);
    chk("R8 whole frame leaves flag clear", f_inc, 1'b0);

    // R4 reserved bits
    w0 = wr_cnt;
    r0 = rd_cnt;
    txn(8'h2A, 8'h77, got);
    chk("R4 reserved write blocked", 16'(wr_cnt - w0), 16'd0);
    chk("R4 register untouched", mem[10], 8'h22);
    txn(8'hCA, 8'h00, got);
    chk("R4 reserved read blocked", 16'(rd_cnt - r0), 16'd0);
    chk("R4 reserved read returns zero", got[7:0], 8'h00);

    // R7 deselected port ignores SCK
    w0 = wr_cnt;
    scs_n = 1'b1;
    xfer(16'h0B55, 16, got);
    wait_clk(6);
    chk("R7 deselected no write", 16'(wr_cnt - w0), 16'd0);
    chk("R7 register 11 untouched", mem[11], 8'h00);
    chk("R7 no incomplete while deselected", f_inc, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule